// File: doc/BRIEF.md
# Bidirectional Column Driver Line Capture

This block is the digital front end of a column (source) driver for a flat panel. On every clock of an active line it accepts two RGB pixels at once: six 8-bit subpixel codes, presented in parallel on one wide data bus. A group pointer places each group of six codes into a line store of `NGROUP * LANES` channels. A start pulse arms the pointer. The fill direction is latched from a direction input on that pulse and runs either from the lowest channel upward or from the highest channel downward. In downward mode the six lanes are also mirrored inside each group.

Two inversion inputs each complement one half of the bus on the same clock the codes are captured. The low half is lanes 0 to 2 and the high half is lanes 3 to 5. When the last group has been written, the block raises its cascade output for that one clock, so the next driver in a chain starts on the following clock without a gap. The block then stops writing until another start pulse arrives. While a load strobe is high, the line store is copied into a hold register that feeds the converters downstream. A new line can be captured during the copy without disturbing the held values.

Top module: `colsrc_capture`

## Requirements
- R1: After reset every held channel reads 0 and `cascade_out` is low.
- R2: With `fill_up` high at the start pulse, lane k of the j-th capture after the start (j from 0) is stored in channel `LANES*j + k`. Channel c occupies `held[c*CW +: CW]`, and lane k is `pix_in[k*CW +: CW]` with bit CW-1 as the MSB.
- R3: With `fill_up` low at the start pulse, lane k of the j-th capture is stored in channel `NCH-1-(LANES*j + k)`. The first capture therefore puts lane 0 in the highest channel.
- R4: `inv_lo` complements lanes 0 to LANES/2-1 and `inv_hi` complements the remaining lanes. Both are sampled with the data on each capture clock.
- R5: The clock on which `start_in` is high captures no data. Capture begins on the next clock. The direction is taken only on the start clock, and later changes of `fill_up` have no effect on the line.
- R6: After NGROUP captures the line closes, and bus data applied afterwards is not written until the next start pulse.
- R7: `cascade_out` is high during exactly the clock of the last capture of a line, and low at all other times.
- R8: On a clock edge with `load` high, the hold register takes the line contents as they stood before that edge. A capture on the same edge goes only to the line store. With `load` low, the held values do not change.
- R9: A start pulse during an open line moves the pointer back to the first group. Groups not yet rewritten keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_in | input | 1 | Start pulse from the previous driver or the controller |
| fill_up | input | 1 | Fill direction, 1 = lowest channel first, latched at start |
| pix_in | input | LANES*CW | Six subpixel codes, lane k at bits k*CW upward |
| inv_lo | input | 1 | Complement lanes of the low half |
| inv_hi | input | 1 | Complement lanes of the high half |
| load | input | 1 | Copy the line store to the hold register |
| cascade_out | output | 1 | Start pulse for the next driver, on the last capture |
| held | output | NGROUP*LANES*CW | Held line, channel c at bits c*CW upward |

## Verification
The bench builds the block with NGROUP = 4 and keeps LANES = 6 and CW = 8, which gives a 24-channel line. That short line puts the closing capture, the cascade pulse and the overrun after a full line only a few clocks apart. It also lets every channel be compared after each load in both fill directions. A restart after two groups, followed by a load that coincides with a capture, shows old and new groups side by side in a single held line.

// File: rtl/srcd_pkg.sv
package srcd_pkg;
    typedef enum logic {
        FILL_DOWN = 1'b0,
        FILL_UP   = 1'b1
    } fill_dir_e;
endpackage

// File: rtl/srcd_lane_prep.sv
// Applies the half-bus inversion and mirrors the lanes for downward fills.
module srcd_lane_prep #(
    parameter int LANES = 6,
    parameter int CW    = 8
) (
    input  logic [LANES*CW-1:0] pix_in,
    input  logic                inv_lo,
    input  logic                inv_hi,
    input  logic                fwd,
    output logic [LANES*CW-1:0] lanes_out
);
    localparam int HALF = LANES / 2;

    logic [LANES-1:0][CW-1:0] raw;
    logic [LANES-1:0][CW-1:0] cond;

    assign raw = pix_in;

    for (genvar k = 0; k < LANES; k++) begin : g_inv
        if (k < HALF) begin : g_lo
            assign cond[k] = raw[k] ^ {CW{inv_lo}};
        end else begin : g_hi
            assign cond[k] = raw[k] ^ {CW{inv_hi}};
        end
    end

    for (genvar p = 0; p < LANES; p++) begin : g_order
        assign lanes_out[p*CW +: CW] = fwd ? cond[p] : cond[LANES-1-p];
    end
endmodule

// File: rtl/srcd_group_ptr.sv
// Group pointer: armed by start, closes itself after NGROUP captures.
module srcd_group_ptr #(
    parameter int NGROUP = 64,
    localparam int PW    = (NGROUP > 1) ? $clog2(NGROUP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_in,
    input  logic          dir_in,
    output logic          wr_en,
    output logic [PW-1:0] wr_slot,
    output logic          fwd,
    output logic          last_cap
);
    import srcd_pkg::*;

    localparam logic [PW-1:0] LAST = PW'(NGROUP - 1);

    typedef struct packed {
        logic          active;
        logic          fwd;
        logic [PW-1:0] ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        wr_en    = st_q.active && !start_in;
        last_cap = wr_en && (st_q.ptr == LAST);
        if (start_in) begin
            st_d.active = 1'b1;
            st_d.fwd    = (dir_in == FILL_UP);
            st_d.ptr    = '0;
        end else if (wr_en) begin
            if (last_cap) begin
                st_d.active = 1'b0;
                st_d.ptr    = '0;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_slot = st_q.fwd ? st_q.ptr : (LAST - st_q.ptr);
    assign fwd     = st_q.fwd;

    AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start_in |=> (st_q.active && st_q.ptr == '0)); // R9
    AST_LINE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (last_cap && !start_in) |=> !st_q.active); // R6
    AST_SINGLE_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        last_cap |=> !last_cap); // R7
endmodule

// File: rtl/srcd_line_store.sv
// Line store written one group per capture, plus the hold register.
module srcd_line_store #(
    parameter int NGROUP   = 64,
    parameter int LANES    = 6,
    parameter int CW       = 8,
    localparam int PW      = (NGROUP > 1) ? $clog2(NGROUP) : 1,
    localparam int NCH     = NGROUP * LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PW-1:0]       wr_slot,
    input  logic [LANES*CW-1:0] wr_lanes,
    input  logic                load,
    output logic [NCH*CW-1:0]   held
);
    logic [LANES-1:0][CW-1:0] lanes;
    logic [NCH-1:0][CW-1:0]   line_d, line_q;
    logic [NCH-1:0][CW-1:0]   hold_d, hold_q;

    assign lanes = wr_lanes;

    always_comb begin
        line_d = line_q;
        for (int g = 0; g < NGROUP; g++) begin
            if (wr_en && wr_slot == PW'(g)) begin
                for (int k = 0; k < LANES; k++) begin
                    line_d[g*LANES + k] = lanes[k];
                end
            end
        end
        hold_d = load ? line_q : hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            hold_q <= '0;
        end else begin
            line_q <= line_d;
            hold_q <= hold_d;
        end
    end

    assign held = hold_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(hold_q)); // R8
    AST_HOLD_TAKES_OLD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (hold_q == $past(line_q))); // R8
    AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(line_q)); // R6
endmodule

// File: rtl/colsrc_capture.sv
module colsrc_capture #(
    parameter int NGROUP = 64,
    parameter int LANES  = 6,
    parameter int CW     = 8,
    localparam int PW    = (NGROUP > 1) ? $clog2(NGROUP) : 1,
    localparam int NCH   = NGROUP * LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_in,
    input  logic                fill_up,
    input  logic [LANES*CW-1:0] pix_in,
    input  logic                inv_lo,
    input  logic                inv_hi,
    input  logic                load,
    output logic                cascade_out,
    output logic [NCH*CW-1:0]   held
);
    logic          wr_en;
    logic [PW-1:0] wr_slot;
    logic          fwd;
    logic          last_cap;
    logic [LANES*CW-1:0] lanes;

    srcd_group_ptr #(.NGROUP(NGROUP)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_in (start_in),
        .dir_in   (fill_up),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .fwd      (fwd),
        .last_cap (last_cap)
    );

    srcd_lane_prep #(.LANES(LANES), .CW(CW)) u_prep (
        .pix_in    (pix_in),
        .inv_lo    (inv_lo),
        .inv_hi    (inv_hi),
        .fwd       (fwd),
        .lanes_out (lanes)
    );

    srcd_line_store #(.NGROUP(NGROUP), .LANES(LANES), .CW(CW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_lanes (lanes),
        .load     (load),
        .held     (held)
    );

    assign cascade_out = last_cap;

    AST_NO_CASCADE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_in |-> !cascade_out); // R5
endmodule

// File: tb/sim_colsrc_capture.sv
module sim_colsrc_capture;
    localparam int NG  = 4;
    localparam int LN  = 6;
    localparam int CW  = 8;
    localparam int NCH = NG * LN;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_in = 1'b0;
    logic              fill_up = 1'b1;
    logic [LN*CW-1:0]  pix_in = '0;
    logic              inv_lo = 1'b0;
    logic              inv_hi = 1'b0;
    logic              load = 1'b0;
    logic              cascade_out;
    logic [NCH*CW-1:0] held;

    logic [7:0] m_line [NCH];
    logic [7:0] m_held [NCH];
    logic       m_fwd;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    colsrc_capture #(.NGROUP(NG), .LANES(LN), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_in(start_in), .fill_up(fill_up),
        .pix_in(pix_in), .inv_lo(inv_lo), .inv_hi(inv_hi), .load(load),
        .cascade_out(cascade_out), .held(held)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [7:0] pat(input int seed, input int g, input int k);
        return 8'(seed + g * 37 + k * 5);
    endfunction

    task automatic check_held(input string req);
        int bad = -1;
        for (int c = 0; c < NCH; c++)
            if (bad < 0 && held[c*CW +: CW] !== m_held[c]) bad = c;
        if (bad < 0) chk(1'b1, req, "held line", 0, 0);
        else chk(1'b0, req, $sformatf("held channel %0d", bad),
                 32'(held[bad*CW +: CW]), 32'(m_held[bad]));
    endtask

    // Start clock: garbage on the bus must not be captured (R5).
    task automatic do_start(input logic dir);
        start_in = 1'b1;
        fill_up  = dir;
        pix_in   = {LN{8'hA5}};
        #1 chk(cascade_out == 1'b0, "R5", "cascade on start", 32'(cascade_out), 0);
        step();
        start_in = 1'b0;
        fill_up  = ~dir; // later direction changes are ignored (R5)
        m_fwd    = dir;
    endtask

    task automatic cap_group(input int g, input int seed, input logic il,
                             input logic ih, input logic strb);
        for (int k = 0; k < LN; k++) pix_in[k*CW +: CW] = pat(seed, g, k);
        inv_lo = il;
        inv_hi = ih;
        load   = strb;
        #1 chk(cascade_out == (g == NG - 1), "R7", "cascade level",
               32'(cascade_out), 32'(g == NG - 1));
        if (strb) for (int c = 0; c < NCH; c++) m_held[c] = m_line[c];
        step();
        load = 1'b0;
        for (int k = 0; k < LN; k++) begin
            int idx = g * LN + k;
            int ch  = m_fwd ? idx : NCH - 1 - idx;
            logic inv = (k < LN / 2) ? il : ih;
            m_line[ch] = pat(seed, g, k) ^ {8{inv}};
        end
    endtask

    task automatic load_line(input logic dir, input int seed, input int mode);
        do_start(dir);
        for (int g = 0; g < NG; g++) begin
            logic il = (mode == 1) || (mode == 3 && g % 2 == 0);
            logic ih = (mode == 2) || (mode == 3 && g % 2 == 1);
            cap_group(g, seed, il, ih, 1'b0);
        end
        pix_in = '0;
        inv_lo = 1'b0;
        inv_hi = 1'b0;
    endtask

    task automatic pulse_load();
        load = 1'b1;
        for (int c = 0; c < NCH; c++) m_held[c] = m_line[c];
        step();
        load = 1'b0;
    endtask

    task automatic t_reset();
        for (int c = 0; c < NCH; c++) begin
            m_line[c] = '0;
            m_held[c] = '0;
        end
        check_held("R1");
        chk(cascade_out == 1'b0, "R1", "cascade after reset", 32'(cascade_out), 0);
    endtask

    task automatic t_forward();
        load_line(1'b1, 3, 0);
        pulse_load();
        check_held("R2");
    endtask

    task automatic t_reverse();
        load_line(1'b0, 71, 0);
        pulse_load();
        check_held("R3");
    endtask

    task automatic t_invert();
        load_line(1'b1, 11, 1);
        pulse_load();
        check_held("R4 low half");
        load_line(1'b0, 29, 2);
        pulse_load();
        check_held("R4 high half");
        load_line(1'b1, 53, 3);
        pulse_load();
        check_held("R4 per clock");
    endtask

    task automatic t_overrun();
        load_line(1'b1, 90, 0);
        for (int i = 0; i < 3; i++) begin
            pix_in = {LN{8'(8'h3C + i)}};
            inv_lo = 1'b1;
            #1 chk(cascade_out == 1'b0, "R7", "cascade after line", 32'(cascade_out), 0);
            step();
        end
        inv_lo = 1'b0;
        pulse_load();
        check_held("R6");
    endtask

    task automatic t_restart_overlap();
        load_line(1'b1, 120, 0);
        pulse_load();
        do_start(1'b1);
        cap_group(0, 7, 1'b0, 1'b0, 1'b0);
        cap_group(1, 7, 1'b0, 1'b0, 1'b0);
        do_start(1'b1);
        cap_group(0, 200, 1'b0, 1'b0, 1'b0);
        cap_group(1, 150, 1'b0, 1'b0, 1'b1);
        check_held("R9");
        check_held("R8 load during capture");
        cap_group(2, 150, 1'b0, 1'b0, 1'b0);
        cap_group(3, 150, 1'b0, 1'b0, 1'b0);
        check_held("R8 stable without load");
        pulse_load();
        check_held("R9 full line after restart");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        step();
        t_reset();
        t_forward();
        t_reverse();
        t_invert();
        t_overrun();
        t_restart_overlap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule